// File: doc/BRIEF.md
# SPI Chip-Select Line Controller

This block drives a set of SPI chip-select lines (four by default). A two-bit index chooses which line is the target. The other lines stay at their idle level. The target line follows one of two sources. In automatic mode it follows the busy flag of the transfer engine, so the line is asserted for the whole burst and released when the burst ends. In manual mode it follows a level given by software.

A single polarity input sets two things at once: the level of an asserted line and the idle level of every other line. When the polarity input is 1, the lines are active-low, so an asserted line reads 0 and an idle line reads 1. When it is 0, the lines are active-high, so an asserted line reads 1 and an idle line reads 0.

The index is captured on every cycle in which no transfer is running. While a burst is in progress the captured index is held, so retargeting the line during a burst only takes effect after the burst. All outputs are registered and follow their inputs one clock later.

Top module: `spi_cs_ctrl`

## Requirements
- R1: While `rst` is high, every line is driven to its idle level, which equals `cs_active_low`, on the next clock edge.
- R2: When `cs_manual` is 0, the target line is asserted one cycle after `xfer_busy` is high and deasserted one cycle after `xfer_busy` is low.
- R3: At most one line differs from the idle level, and only the line whose number equals the effective index may differ.
- R4: When `cs_manual` is 1, the target line is asserted exactly when `cs_manual_level` is 1, one cycle later, whatever the value of `xfer_busy`.
- R5: An asserted line is driven to the inverse of `cs_active_low`, and an idle line is driven to `cs_active_low`.
- R6: While `xfer_busy` is high, changes on `cs_sel` have no effect. The effective index is the value of `cs_sel` from the last cycle in which `xfer_busy` was low, and a new value is used from the first cycle in which `xfer_busy` is low again.
- R7: When `cs_manual` is 0, `cs_manual_level` has no effect on any line.
- R8: After reset the effective index is 0 until `cs_sel` is first captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_busy | input | 1 | High while the transfer engine runs a burst |
| cs_sel | input | 2 | Index of the target line |
| cs_manual | input | 1 | 1 = software drives the target line, 0 = the line follows bursts |
| cs_manual_level | input | 1 | Assert state of the target line in manual mode |
| cs_active_low | input | 1 | 1 = lines are active-low, so idle lines read high |
| cs_lines | output | 4 | Registered chip-select outputs |

## Verification
The assertions assume that `rst` is held high for at least one clock before it is released. They compare each line with the values that the control inputs had one cycle earlier, so they expect those inputs to be sampled, and held for a whole cycle, at the rising edge. The bench meets both conditions: it changes every input only on the falling edge, and it starts with several reset cycles. The random stimulus keeps `xfer_busy` in bursts of a few cycles and switches mode, polarity and index freely. Directed sequences cover retargeting in the middle of a burst and toggling the manual level while in automatic mode.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic {
    CS_MODE_AUTO   = 1'b0,
    CS_MODE_MANUAL = 1'b1
  } cs_mode_e;
endpackage

// File: rtl/cs_index_hold.sv
module cs_index_hold #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic [IDX_W-1:0] idx_in,
  output logic [IDX_W-1:0] idx_eff
);
  logic [IDX_W-1:0] idx_q;

  // hold the captured index during a burst, follow the input otherwise
  assign idx_eff = busy ? idx_q : idx_in;

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_eff;
  end

  p_index_hold_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> (idx_q == $past(idx_q)));
endmodule

// File: rtl/cs_assert_sel.sv
module cs_assert_sel
  import spi_cs_pkg::*;
(
  input  cs_mode_e mode,
  input  logic     manual_level,
  input  logic     busy,
  output logic     assert_o
);
  always_comb begin
    unique case (mode)
      CS_MODE_MANUAL: assert_o = manual_level;
      default:        assert_o = busy;
    endcase
  end
endmodule

// File: rtl/cs_line_decode.sv
module cs_line_decode #(
  parameter int NUM_CS = 4,
  parameter int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic              assert_i,
  input  logic              active_low,
  output logic [NUM_CS-1:0] lines
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    logic hit;
    assign hit = assert_i && (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) lines[g] <= active_low;
      else     lines[g] <= hit ? ~active_low : active_low;
    end
  end
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_busy,
  input  logic [IDX_W-1:0]  cs_sel,
  input  logic              cs_manual,
  input  logic              cs_manual_level,
  input  logic              cs_active_low,
  output logic [NUM_CS-1:0] cs_lines
);
  logic [IDX_W-1:0] idx_eff;
  logic             line_on;
  cs_mode_e         mode;

  assign mode = cs_manual ? CS_MODE_MANUAL : CS_MODE_AUTO;

  cs_index_hold #(.IDX_W(IDX_W)) u_hold (
    .clk(clk), .rst(rst), .busy(xfer_busy), .idx_in(cs_sel), .idx_eff(idx_eff)
  );

  cs_assert_sel u_sel (
    .mode(mode), .manual_level(cs_manual_level), .busy(xfer_busy), .assert_o(line_on)
  );

  cs_line_decode #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst(rst), .idx(idx_eff), .assert_i(line_on),
    .active_low(cs_active_low), .lines(cs_lines)
  );

  // previous-cycle copies of the controls, used only by the assertions
  logic was_rst, prev_al, prev_man, prev_lvl, prev_busy, seen_clk;
  always_ff @(posedge clk) begin
    was_rst   <= rst;
    prev_al   <= cs_active_low;
    prev_man  <= cs_manual;
    prev_lvl  <= cs_manual_level;
    prev_busy <= xfer_busy;
    seen_clk  <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (seen_clk === 1'b1 && was_rst === 1'b1)
      p_reset_idle_r1: assert (cs_lines == {NUM_CS{prev_al}});
  end

  p_single_line_r3: assert property (@(posedge clk) disable iff (rst || was_rst)
    $countones(cs_lines ^ {NUM_CS{prev_al}}) <= 1);

  p_auto_busy_r2: assert property (@(posedge clk) disable iff (rst || was_rst)
    (!prev_man && prev_busy) |-> (cs_lines != {NUM_CS{prev_al}}));

  p_auto_idle_r7: assert property (@(posedge clk) disable iff (rst || was_rst)
    (!prev_man && !prev_busy) |-> (cs_lines == {NUM_CS{prev_al}}));

  p_manual_off_r4: assert property (@(posedge clk) disable iff (rst || was_rst)
    (prev_man && !prev_lvl) |-> (cs_lines == {NUM_CS{prev_al}}));
endmodule

// File: tb/spi_cs_ctrl_test.sv
module spi_cs_ctrl_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst, busy, man, lvl, al;
  logic [1:0] sel;
  logic [N-1:0] lines;
  int total = 0, bad = 0;
  logic [1:0] m_idx;
  bit done = 0;

  always #5 clk = ~clk;

  spi_cs_ctrl #(.NUM_CS(N)) uut (
    .clk(clk), .rst(rst), .xfer_busy(busy), .cs_sel(sel), .cs_manual(man),
    .cs_manual_level(lvl), .cs_active_low(al), .cs_lines(lines)
  );

  function automatic logic [N-1:0] expect_lines(logic [1:0] idx, logic on, logic pol);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (on && idx == i[1:0]) ? ~pol : pol;
    return v;
  endfunction

  task automatic step(input logic r, input logic b, input logic [1:0] s,
                      input logic m, input logic l, input logic p, input string tag);
    logic [N-1:0] exp;
    @(negedge clk);
    rst = r; busy = b; sel = s; man = m; lvl = l; al = p;
    if (r) begin
      m_idx = 2'd0;
      exp = {N{p}};
    end else begin
      if (!b) m_idx = s;
      exp = expect_lines(m_idx, m ? l : b, p);
    end
    @(posedge clk);
    #2;
    total++;
    if (lines !== exp) begin
      bad++;
      $display("FAIL %s: lines=%b expected=%b", tag, lines, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; busy = 0; sel = 0; man = 0; lvl = 0; al = 1;
    // R1 reset idle in both polarities
    step(1, 0, 2'd2, 0, 0, 1, "R1");
    step(1, 1, 2'd3, 1, 1, 0, "R1");
    step(1, 0, 2'd1, 1, 1, 1, "R1");
    // R8 index is 0 straight after reset: first busy cycle keeps index 0
    step(0, 1, 2'd3, 0, 0, 1, "R8");
    step(0, 0, 2'd1, 0, 0, 1, "R2");
    // R6 retarget during a burst
    step(0, 1, 2'd1, 0, 0, 1, "R6");
    step(0, 1, 2'd3, 0, 0, 1, "R6");
    step(0, 1, 2'd0, 0, 0, 1, "R6");
    step(0, 0, 2'd3, 0, 0, 1, "R6");
    step(0, 1, 2'd2, 0, 0, 1, "R6");
    // R7 manual level ignored in auto mode
    step(0, 0, 2'd2, 0, 1, 1, "R7");
    step(0, 1, 2'd2, 0, 0, 0, "R7 R5");
    // R4 manual mode over busy
    step(0, 1, 2'd2, 1, 0, 0, "R4");
    step(0, 0, 2'd3, 1, 1, 0, "R4 R5");
    step(0, 0, 2'd3, 1, 1, 1, "R4 R5");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic b, m, l, p, r;
      logic [1:0] s;
      r = ($urandom % 200) == 0;
      b = ($urandom % 4) != 0 ? busy : ~busy;
      m = ($urandom % 8) == 0 ? ~man : man;
      l = $urandom;
      p = ($urandom % 16) == 0 ? ~al : al;
      s = $urandom;
      step(r, b, s, m, l, p, r ? "R1" : (m ? "R4 R3 R5" : "R2 R3 R5 R6 R7"));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule